// File: doc/BRIEF.md
# Register Access and Privilege Checker

This block sits in the decode stage of a small 32-bit processor. It holds the eleven register-ID-addressable 32-bit registers (eight general registers, the stack pointer, the instruction pointer and the flags word) and the 8-bit privilege mode word. It also holds the kernel stack pointer and the interrupt table pointer, which have no register ID.

For each decoded instruction the decoder presents up to two one-byte register IDs and a flag that marks the opcode as privileged. One cycle later the block reports one of three outcomes, each with its interrupt vector number: operands accepted, invalid-instruction fault, or protection fault. It also gives the datapath one combinational read port and one write port into the register file.

On interrupt entry the block drops to the kernel tier. When it leaves a non-privileged tier, it also reloads the stack pointer from the kernel stack pointer. A separate mode load models the return from interrupt.

Top module: `regchk_top`

## Requirements
- R1: The valid register IDs are 0x00..0x0a: general registers 0..7, stack pointer 8, instruction pointer 9, flags 10. If `chk_valid` is high and an operand whose use bit is set carries an ID above 0x0a, `chk_inv` is high in the next cycle with `chk_vec` = INV_VEC (default 0x06). The ID of an operand whose use bit is clear is ignored.
- R2: Mode bit 0 clear means a privileged tier: Kernel 0b00 or Supervisor 0b10. Mode bit 0 set means a non-privileged tier: User 0b01 or Driver 0b11. A checked privileged opcode in a non-privileged tier gives `chk_prot` with `chk_vec` = 0x03 in the next cycle. In a privileged tier the same opcode gives no fault.
- R3: The invalid-ID fault takes priority over the protection fault. A check with neither fault gives `chk_ok` with `chk_vec` = 0x00. In the cycle after a check, exactly one of `chk_ok`/`chk_inv`/`chk_prot` is high. All three are low, with `chk_vec` = 0, in a cycle that follows no check.
- R4: A check is judged against the mode held before the clock edge, even if a mode load or an interrupt entry occurs in the same cycle.
- R5: `rd_data` shows the current value of register `rd_id` combinationally, and shows 0 for an invalid ID. When `wr_en` is high and `wr_id` is valid, the register takes `wr_data` at the clock edge. A write to an invalid ID changes nothing.
- R6: A write to the flags register (ID 0x0a) keeps only bits 3:0. Bits 31:4 read as zero.
- R7: When `irq_enter` is high, the mode becomes 0x00 at the next edge. If mode bit 0 was set, the stack pointer also takes the current kernel stack pointer. Otherwise the stack pointer is left alone.
- R8: In the same cycle, `irq_enter` overrides both a `mode_wr_en` load and a register-port write to the stack pointer when it swaps the stack pointer.
- R9: Without `irq_enter`, `mode_wr_en` loads all 8 bits of `mode_wr_data` into the mode, which is shown on `mode_out`.
- R10: `ksp_wr_en` and `itp_wr_en` update the kernel stack pointer and the interrupt table pointer only when mode bit 0 is clear. In a non-privileged tier these writes are ignored. `ksp_out` and `itp_out` show the current values.
- R11: While `rst_n` is low, all registers, the mode and both pointers clear to 0, which is the Kernel tier. The check outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Decoded instruction present for checking |
| priv_op | input | 1 | Opcode is privileged |
| use_a | input | 1 | Operand A carries a register ID |
| id_a | input | 8 | Operand A register ID |
| use_b | input | 1 | Operand B carries a register ID |
| id_b | input | 8 | Operand B register ID |
| chk_ok | output | 1 | Previous check accepted |
| chk_inv | output | 1 | Previous check raised invalid-instruction fault |
| chk_prot | output | 1 | Previous check raised protection fault |
| chk_vec | output | 8 | Vector number of the reported outcome |
| rd_id | input | 8 | Read port register ID |
| rd_data | output | 32 | Read port data |
| wr_en | input | 1 | Write port enable |
| wr_id | input | 8 | Write port register ID |
| wr_data | input | 32 | Write port data |
| irq_enter | input | 1 | Interrupt entry |
| mode_wr_en | input | 1 | Mode load (interrupt return) |
| mode_wr_data | input | 8 | Mode value to load |
| mode_out | output | 8 | Current mode |
| ksp_wr_en | input | 1 | Kernel stack pointer write |
| ksp_wr_data | input | 32 | Kernel stack pointer write value |
| ksp_out | output | 32 | Current kernel stack pointer |
| itp_wr_en | input | 1 | Interrupt table pointer write |
| itp_wr_data | input | 32 | Interrupt table pointer write value |
| itp_out | output | 32 | Current interrupt table pointer |

## Verification
The stack pointer can be written from two sources in one cycle: an ordinary register-port write, and the reload from the kernel stack pointer on interrupt entry from a non-privileged tier. The bench provokes this with a directed cycle and with random stimulus that often raises `wr_en`, `irq_enter` and `mode_wr_en` together. It judges the result by reading ID 8 back and comparing with a model in which the interrupt reload wins. The same cycles also check that a concurrent privilege check still uses the pre-edge mode.

// File: rtl/regchk_pkg.sv
package regchk_pkg;
    localparam int DATA_W  = 32;
    localparam int MODE_W  = 8;
    localparam int VEC_W   = 8;
    localparam int ID_W    = 8;
    localparam int NREG    = 11;
    localparam int IDX_W   = $clog2(NREG);
    localparam int FL_BITS = 4;
    localparam int NPORT   = 4;   // id_a, id_b, wr_id, rd_id

    localparam logic [IDX_W-1:0] IDX_SP = IDX_W'(8);
    localparam logic [IDX_W-1:0] IDX_FL = IDX_W'(10);
    localparam logic [VEC_W-1:0] VEC_PROT = VEC_W'(3);
    localparam logic [VEC_W-1:0] VEC_NONE = '0;

    typedef enum logic [1:0] {
        OC_NONE = 2'd0,
        OC_OK   = 2'd1,
        OC_INV  = 2'd2,
        OC_PROT = 2'd3
    } outcome_e;

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic [MODE_W-1:0]           mode;
        logic [DATA_W-1:0]           ksp;
        logic [DATA_W-1:0]           itp;
        outcome_e                    res;
        logic [VEC_W-1:0]            vec;
    } state_t;
endpackage

// File: rtl/regchk_iddec.sv
module regchk_iddec
    import regchk_pkg::*;
(
    input  logic [ID_W-1:0]  id,
    output logic             ok,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        ok  = (id <= ID_W'(NREG - 1));
        idx = ok ? id[IDX_W-1:0] : '0;
    end
endmodule

// File: rtl/regchk_tier.sv
module regchk_tier
    import regchk_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output logic              is_priv
);
    // bit 0 (virtual) set -> User or Driver: non-privileged
    always_comb is_priv = ~mode[0];
endmodule

// File: rtl/regchk_outcome.sv
module regchk_outcome
    import regchk_pkg::*;
#(
    parameter logic [VEC_W-1:0] INV_VEC = 8'h06
) (
    input  logic             bad_a,
    input  logic             bad_b,
    input  logic             priv_op,
    input  logic             is_priv,
    output outcome_e         res,
    output logic [VEC_W-1:0] vec
);
    always_comb begin
        if (bad_a || bad_b) begin
            res = OC_INV;
            vec = INV_VEC;
        end else if (priv_op && !is_priv) begin
            res = OC_PROT;
            vec = VEC_PROT;
        end else begin
            res = OC_OK;
            vec = VEC_NONE;
        end
    end
endmodule

// File: rtl/regchk_top.sv
module regchk_top
    import regchk_pkg::*;
#(
    parameter logic [VEC_W-1:0] INV_VEC = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic              priv_op,
    input  logic              use_a,
    input  logic [ID_W-1:0]   id_a,
    input  logic              use_b,
    input  logic [ID_W-1:0]   id_b,
    output logic              chk_ok,
    output logic              chk_inv,
    output logic              chk_prot,
    output logic [VEC_W-1:0]  chk_vec,
    input  logic [ID_W-1:0]   rd_id,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_enter,
    input  logic              mode_wr_en,
    input  logic [MODE_W-1:0] mode_wr_data,
    output logic [MODE_W-1:0] mode_out,
    input  logic              ksp_wr_en,
    input  logic [DATA_W-1:0] ksp_wr_data,
    output logic [DATA_W-1:0] ksp_out,
    input  logic              itp_wr_en,
    input  logic [DATA_W-1:0] itp_wr_data,
    output logic [DATA_W-1:0] itp_out
);
    localparam int P_A  = 0;
    localparam int P_B  = 1;
    localparam int P_WR = 2;
    localparam int P_RD = 3;
    localparam logic [DATA_W-1:0] FL_MASK = DATA_W'((1 << FL_BITS) - 1);

    state_t cur_q, nxt_d;

    logic [ID_W-1:0]  port_id  [NPORT];
    logic             port_ok  [NPORT];
    logic [IDX_W-1:0] port_idx [NPORT];

    always_comb begin
        port_id[P_A]  = id_a;
        port_id[P_B]  = id_b;
        port_id[P_WR] = wr_id;
        port_id[P_RD] = rd_id;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        regchk_iddec u_dec (
            .id  (port_id[p]),
            .ok  (port_ok[p]),
            .idx (port_idx[p])
        );
    end

    logic is_priv;
    regchk_tier u_tier (
        .mode    (cur_q.mode),
        .is_priv (is_priv)
    );

    outcome_e         oc_res;
    logic [VEC_W-1:0] oc_vec;
    regchk_outcome #(.INV_VEC(INV_VEC)) u_oc (
        .bad_a   (use_a && !port_ok[P_A]),
        .bad_b   (use_b && !port_ok[P_B]),
        .priv_op (priv_op),
        .is_priv (is_priv),
        .res     (oc_res),
        .vec     (oc_vec)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.res = OC_NONE;
        nxt_d.vec = VEC_NONE;
        if (chk_valid) begin
            nxt_d.res = oc_res;
            nxt_d.vec = oc_vec;
        end
        if (wr_en && port_ok[P_WR]) begin
            if (port_idx[P_WR] == IDX_FL)
                nxt_d.regs[port_idx[P_WR]] = wr_data & FL_MASK;
            else
                nxt_d.regs[port_idx[P_WR]] = wr_data;
        end
        if (ksp_wr_en && is_priv) nxt_d.ksp = ksp_wr_data;
        if (itp_wr_en && is_priv) nxt_d.itp = itp_wr_data;
        if (mode_wr_en) nxt_d.mode = mode_wr_data;
        if (irq_enter) begin
            nxt_d.mode = '0;
            if (!is_priv) nxt_d.regs[IDX_SP] = cur_q.ksp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    logic [DATA_W-1:0] sp_w;
    always_comb begin
        chk_ok   = (cur_q.res == OC_OK);
        chk_inv  = (cur_q.res == OC_INV);
        chk_prot = (cur_q.res == OC_PROT);
        chk_vec  = cur_q.vec;
        rd_data  = port_ok[P_RD] ? cur_q.regs[port_idx[P_RD]] : '0;
        mode_out = cur_q.mode;
        ksp_out  = cur_q.ksp;
        itp_out  = cur_q.itp;
        sp_w     = cur_q.regs[IDX_SP];
    end
endmodule

// File: rtl/regchk_chk.sv
module regchk_chk
    import regchk_pkg::*;
#(
    parameter logic [VEC_W-1:0] INV_VEC = 8'h06
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chk_valid,
    input logic              priv_op,
    input logic              use_a,
    input logic [ID_W-1:0]   id_a,
    input logic              use_b,
    input logic [ID_W-1:0]   id_b,
    input logic              chk_ok,
    input logic              chk_inv,
    input logic              chk_prot,
    input logic [VEC_W-1:0]  chk_vec,
    input logic              irq_enter,
    input logic              ksp_wr_en,
    input logic [MODE_W-1:0] mode_out,
    input logic [DATA_W-1:0] ksp_out,
    input logic [DATA_W-1:0] sp_val
);
    assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chk_ok, chk_inv, chk_prot}));

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !(chk_ok || chk_inv || chk_prot));

    assert_inv_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && ((use_a && id_a > 8'h0a) || (use_b && id_b > 8'h0a)))
        |=> (chk_inv && chk_vec == INV_VEC));

    assert_prot_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && priv_op && mode_out[0] && !(use_a && id_a > 8'h0a)
         && !(use_b && id_b > 8'h0a)) |=> (chk_prot && chk_vec == 8'h03));

    assert_no_prot_priv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !mode_out[0]) |=> !chk_prot);

    assert_irq_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> (mode_out == '0));

    assert_irq_sp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_enter && mode_out[0]) |=> (sp_val == $past(ksp_out)));

    assert_ksp_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ksp_wr_en && mode_out[0]) |=> $stable(ksp_out));
endmodule

bind regchk_top regchk_chk #(.INV_VEC(INV_VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (chk_valid),
    .priv_op   (priv_op),
    .use_a     (use_a),
    .id_a      (id_a),
    .use_b     (use_b),
    .id_b      (id_b),
    .chk_ok    (chk_ok),
    .chk_inv   (chk_inv),
    .chk_prot  (chk_prot),
    .chk_vec   (chk_vec),
    .irq_enter (irq_enter),
    .ksp_wr_en (ksp_wr_en),
    .mode_out  (mode_out),
    .ksp_out   (ksp_out),
    .sp_val    (sp_w)
);

// File: tb/regchk_top_bench.sv
module regchk_top_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        chk_valid = 0, priv_op = 0, use_a = 0, use_b = 0;
    logic [7:0]  id_a = 0, id_b = 0, rd_id = 0, wr_id = 0, mode_wr_data = 0;
    logic        wr_en = 0, irq_enter = 0, mode_wr_en = 0, ksp_wr_en = 0, itp_wr_en = 0;
    logic [31:0] wr_data = 0, ksp_wr_data = 0, itp_wr_data = 0;
    logic        chk_ok, chk_inv, chk_prot;
    logic [7:0]  chk_vec, mode_out;
    logic [31:0] rd_data, ksp_out, itp_out;

    regchk_top u_regchk_top (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .priv_op(priv_op),
        .use_a(use_a), .id_a(id_a), .use_b(use_b), .id_b(id_b),
        .chk_ok(chk_ok), .chk_inv(chk_inv), .chk_prot(chk_prot), .chk_vec(chk_vec),
        .rd_id(rd_id), .rd_data(rd_data), .wr_en(wr_en), .wr_id(wr_id), .wr_data(wr_data),
        .irq_enter(irq_enter), .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
        .mode_out(mode_out), .ksp_wr_en(ksp_wr_en), .ksp_wr_data(ksp_wr_data),
        .ksp_out(ksp_out), .itp_wr_en(itp_wr_en), .itp_wr_data(itp_wr_data), .itp_out(itp_out)
    );

    int checks = 0, errors = 0, cycles = 0;
    logic [31:0] m_regs [11];
    logic [7:0]  m_mode;
    logic [31:0] m_ksp, m_itp;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_outcome(bit cv, bit pv, bit ua, logic [7:0] a,
                                               bit ub, logic [7:0] b, logic [7:0] md);
        if (!cv) return 3'b000;
        if ((ua && a > 8'h0a) || (ub && b > 8'h0a)) return 3'b010;  // inv
        if (pv && md[0]) return 3'b001;                             // prot
        return 3'b100;                                              // ok
    endfunction

    function automatic logic [7:0] exp_vec(logic [2:0] oc);
        case (oc)
            3'b010:  return 8'h06;
            3'b001:  return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] id);
        return (id <= 8'h0a) ? m_regs[id[3:0]] : 32'h0;
    endfunction

    task automatic cyc(bit cv, bit pv, bit ua, logic [7:0] a, bit ub, logic [7:0] b,
                       logic [7:0] rid, bit we, logic [7:0] wid, logic [31:0] wd,
                       bit irq, bit mwe, logic [7:0] md, bit kwe, logic [31:0] kd,
                       bit iwe, logic [31:0] idt);
        logic [2:0] oc;
        string tg;
        chk_valid = cv; priv_op = pv; use_a = ua; id_a = a; use_b = ub; id_b = b;
        rd_id = rid; wr_en = we; wr_id = wid; wr_data = wd; irq_enter = irq;
        mode_wr_en = mwe; mode_wr_data = md; ksp_wr_en = kwe; ksp_wr_data = kd;
        itp_wr_en = iwe; itp_wr_data = idt;
        oc = exp_outcome(cv, pv, ua, a, ub, b, m_mode);
        @(negedge clk);
        // model update, in the same order of precedence as the requirements
        if (we && wid <= 8'h0a) m_regs[wid[3:0]] = (wid == 8'h0a) ? (wd & 32'hf) : wd;
        if (kwe && !m_mode[0]) m_ksp = kd;
        if (iwe && !m_mode[0]) m_itp = idt;
        if (irq && m_mode[0]) m_regs[8] = (kwe && !m_mode[0]) ? m_ksp : m_ksp;
        if (irq) m_mode = 8'h00;
        else if (mwe) m_mode = md;
        tg = (cv && (mwe || irq)) ? "R4" : (oc == 3'b010) ? "R1" : (oc == 3'b001) ? "R2" : "R3";
        check(tg, {29'd0, chk_ok, chk_inv, chk_prot}, {29'd0, oc});
        check(tg, {24'd0, chk_vec}, {24'd0, exp_vec(oc)});
        check(irq ? "R7" : mwe ? "R9" : "R7", {24'd0, mode_out}, {24'd0, m_mode});
        check("R10", ksp_out, m_ksp);
        check("R10", itp_out, m_itp);
        tg = (rid == 8'h08 && irq && we) ? "R8" : (rid == 8'h08 && irq) ? "R7" :
             (rid == 8'h0a) ? "R6" : "R5";
        check(tg, rd_data, exp_read(rid));
    endtask

    task automatic idle(logic [7:0] rid);
        cyc(0,0,0,0,0,0, rid, 0,0,0, 0,0,0, 0,0, 0,0);
    endtask

    function automatic logic [7:0] rnd_id();
        int unsigned r = $urandom % 16;
        if (r < 13) return 8'(r);
        return 8'($urandom);
    endfunction

    initial begin
        for (int i = 0; i < 11; i++) m_regs[i] = 32'h0;
        m_mode = 0; m_ksp = 0; m_itp = 0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        check("R11", {29'd0, chk_ok, chk_inv, chk_prot}, 32'd0);
        check("R11", {24'd0, mode_out}, 32'd0);
        check("R11", ksp_out, 32'd0);
        check("R11", rd_data, 32'd0);
        // R10 pointer writes in Kernel tier
        cyc(0,0,0,0,0,0, 0, 0,0,0, 0,0,0, 1,32'hcafe0000, 1,32'h00001000);
        // R5 write/read, invalid write ignored, invalid read zero
        cyc(0,0,0,0,0,0, 3, 1,8'h03,32'h11223344, 0,0,0, 0,0, 0,0);
        cyc(0,0,0,0,0,0, 8'h0b, 1,8'h0b,32'hdeadbeef, 0,0,0, 0,0, 0,0);
        idle(3);
        // R6 flags mask
        cyc(0,0,0,0,0,0, 8'h0a, 1,8'h0a,32'hffffffff, 0,0,0, 0,0, 0,0);
        // R1 boundaries 0x0a valid, 0x0b invalid, unused operand ignored
        cyc(1,1,1,8'h0a,1,8'h00, 0, 0,0,0, 0,0,0, 0,0, 0,0);
        cyc(1,0,1,8'h0b,0,8'h00, 0, 0,0,0, 0,0,0, 0,0, 0,0);
        cyc(1,0,0,8'hff,1,8'h07, 0, 0,0,0, 0,0,0, 0,0, 0,0);
        cyc(1,0,1,8'h01,1,8'hff, 0, 0,0,0, 0,0,0, 0,0, 0,0);
        // R4: mode load to User with a same-cycle privileged check
        cyc(1,1,1,8'h01,0,0, 0, 0,0,0, 0,1,8'h01, 0,0, 0,0);
        // R2 protection in User, R3 invalid wins
        cyc(1,1,1,8'h01,0,0, 0, 0,0,0, 0,0,0, 0,0, 0,0);
        cyc(1,1,1,8'h20,0,0, 0, 0,0,0, 0,0,0, 0,0, 0,0);
        // R10 writes ignored in User
        cyc(0,0,0,0,0,0, 0, 0,0,0, 0,0,0, 1,32'h12345678, 1,32'h9999);
        // R8 interrupt entry with same-cycle sp write and mode load
        cyc(0,0,0,0,0,0, 8, 1,8'h08,32'h00005555, 1,1,8'h03, 0,0, 0,0);
        // R9 Supervisor no fault, Driver faults, R7 swap from Driver
        cyc(0,0,0,0,0,0, 8, 1,8'h08,32'h00007777, 0,1,8'h02, 0,0, 0,0);
        cyc(1,1,0,0,0,0, 8, 0,0,0, 0,1,8'h03, 0,0, 0,0);
        cyc(1,1,0,0,0,0, 8, 0,0,0, 1,0,0, 0,0, 0,0);
        cyc(0,0,0,0,0,0, 8, 0,0,0, 1,0,0, 0,0, 0,0);
        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] md;
            int unsigned s = $urandom % 6;
            md = (s < 4) ? 8'(s) : 8'($urandom);
            cyc(($urandom % 4) != 0, $urandom % 2, $urandom % 2, rnd_id(), $urandom % 2, rnd_id(),
                rnd_id(), $urandom % 2, rnd_id(), $urandom,
                ($urandom % 8) == 0, ($urandom % 5) == 0, md,
                ($urandom % 4) == 0, $urandom, ($urandom % 4) == 0, $urandom);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule